// File: doc/BRIEF.md
# I2C Slave Reception Status Flags

This block keeps the receive-side status of a multi-master I2C controller as it acts as a slave. A separate bus front end decodes the line activity and passes on single-cycle strobes: START, STOP, a completed address byte, each received data bit, and the level sampled in the acknowledge slot. From these strobes the block keeps three flags. The first holds the most recent received bit, which after an acknowledge slot is the acknowledge result. The second records that a general call arrived. The third records that this device was addressed, either by its own address or by a general call.

Software reads the flags through a read-only status word and controls them with an interface enable, a 7-bit own-address value, an addressing-mode select, a data register write strobe and a software reset pulse. Each flag changes on the clock edge that follows the strobe causing it. When a set condition and a clear condition arrive in the same cycle, the clear wins.

Top module: `i2c_slv_status`

## Requirements
- R1: While reset is asserted, and on leaving reset, all three flags and the whole status word read 0.
- R2: A data-bit strobe loads the received bit value into the last-bit flag on the next clock edge.
- R3: An acknowledge-slot strobe loads the sampled level into the last-bit flag: 0 means an ACK was returned and 1 means none was returned. If both strobes occur in the same cycle, the acknowledge strobe wins.
- R4: A data register write clears the last-bit flag to 0, and it takes priority over both bit strobes in the same cycle.
- R5: The general-call flag is set when an address byte equal to 8'h00 is received while the interface is enabled, the device is not master and 7-bit addressing is selected.
- R6: The general-call flag is cleared by START, by STOP, or while the enable is 0. A clear takes priority over a set in the same cycle.
- R7: The address-match flag is set when bits [7:1] of a received address byte equal the own address, whatever the value of bit 0 (R/W). The same conditions as R5 apply: enabled, not master, 7-bit mode.
- R8: A general call (address byte 8'h00) also sets the address-match flag.
- R9: The address-match flag is cleared by a data register write while enabled, while the enable is 0, or by the software reset pulse. A clear takes priority over a set.
- R10: With 10-bit addressing selected (mode select = 1), or in master mode, an address byte changes neither the general-call flag nor the address-match flag.
- R11: Status word bit 0 is the last-bit flag, bit 1 the general-call flag and bit 2 the address-match flag. Bits 7:3 always read 0.
- R12: Each flag changes exactly one clock edge after the strobe that causes it and keeps its value in cycles with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Interface enable |
| own_addr | input | 7 | Own slave address |
| addr_10b | input | 1 | Addressing-mode select, 1 = 10-bit (no comparison) |
| mst_mode | input | 1 | 1 while the controller is bus master |
| start_stb | input | 1 | START condition detected |
| stop_stb | input | 1 | STOP condition detected |
| addr_stb | input | 1 | Address byte complete |
| rx_byte | input | 8 | Received address byte, R/W in bit 0 |
| bit_stb | input | 1 | Data bit received |
| bit_val | input | 1 | Value of the received data bit |
| ack_stb | input | 1 | Acknowledge slot sampled |
| ack_lvl | input | 1 | SDA level in the acknowledge slot |
| dr_wr | input | 1 | Data register write strobe |
| sw_rst | input | 1 | Software reset pulse |
| lrb_flag | output | 1 | Last received bit / acknowledge result |
| gcall_flag | output | 1 | General call detected |
| match_flag | output | 1 | Slave address matched |
| status_word | output | 8 | Packed read-only status |

## Verification
The hardest cases to reach are cycles where a set and a clear for the same flag coincide. Examples are a general-call byte arriving together with a STOP, and a matching address arriving while the enable drops. Directed steps line these strobes up on the same cycle. A random phase then drives every strobe at once, with address bytes drawn often from the own address and from 8'h00, so that set and clear meet many more times. A behavioural model compares all flags every clock.

// File: rtl/i2c_ss_pkg.sv
package i2c_ss_pkg;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned BYTE_W  = ADDR_W + 1;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned LRB_POS = 0;
  localparam int unsigned GC_POS  = 1;
  localparam int unsigned AM_POS  = 2;
  localparam int unsigned N_FLAGS = 3;
endpackage

// File: rtl/i2c_ss_addr_cmp.sv
module i2c_ss_addr_cmp #(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned BYTE_W = ADDR_W + 1
) (
  input  logic              addr_stb,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              if_en,
  input  logic              addr_10b,
  input  logic              mst_mode,
  output logic              gc_hit,
  output logic              am_hit
);
  logic qualify;
  logic zero_byte;
  logic own_eq;

  always_comb begin
    qualify   = addr_stb && if_en && !addr_10b && !mst_mode;
    zero_byte = (rx_byte == '0);
    own_eq    = (rx_byte[BYTE_W-1:1] == own_addr);
    gc_hit    = qualify && zero_byte;
    am_hit    = qualify && (own_eq || zero_byte);
  end
endmodule

// File: rtl/i2c_ss_flag.sv
module i2c_ss_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic q_nxt;
  logic upd;

  always_comb begin
    upd   = set_i || clr_i;
    q_nxt = q;
    if (clr_i)      q_nxt = 1'b0;
    else if (set_i) q_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (upd) q <= q_nxt;
  end
endmodule

// File: rtl/i2c_ss_lrb.sv
module i2c_ss_lrb (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bit_val,
  input  logic ack_stb,
  input  logic ack_lvl,
  input  logic dr_wr,
  output logic q
);
  logic q_nxt;
  logic upd;

  always_comb begin
    upd   = bit_stb || ack_stb || dr_wr;
    q_nxt = q;
    if (dr_wr)        q_nxt = 1'b0;
    else if (ack_stb) q_nxt = ack_lvl;
    else if (bit_stb) q_nxt = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (upd) q <= q_nxt;
  end

  // R4: a register write leaves the flag at 0
  a_r4_lrb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |=> !q);
  // R3: acknowledge level is loaded
  a_r3_ack_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && !dr_wr) |=> (q == $past(ack_lvl)));
  // R2: data bit is loaded
  a_r2_bit_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !ack_stb && !dr_wr) |=> (q == $past(bit_val)));
  // R12: no strobe, no change
  a_r12_lrb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && !ack_stb && !dr_wr) |=> $stable(q));
endmodule

// File: rtl/i2c_slv_status.sv
module i2c_slv_status
  import i2c_ss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr_10b,
  input  logic              mst_mode,
  input  logic              start_stb,
  input  logic              stop_stb,
  input  logic              addr_stb,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              ack_stb,
  input  logic              ack_lvl,
  input  logic              dr_wr,
  input  logic              sw_rst,
  output logic              lrb_flag,
  output logic              gcall_flag,
  output logic              match_flag,
  output logic [STAT_W-1:0] status_word
);
  logic gc_hit, am_hit;
  logic gc_clr, am_clr;
  logic [N_FLAGS-1:0] flag_vec;

  i2c_ss_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .addr_stb (addr_stb),
    .rx_byte  (rx_byte),
    .own_addr (own_addr),
    .if_en    (if_en),
    .addr_10b (addr_10b),
    .mst_mode (mst_mode),
    .gc_hit   (gc_hit),
    .am_hit   (am_hit)
  );

  always_comb begin
    gc_clr = start_stb || stop_stb || !if_en;
    am_clr = (dr_wr && if_en) || !if_en || sw_rst;
  end

  i2c_ss_lrb u_lrb (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .ack_stb (ack_stb),
    .ack_lvl (ack_lvl),
    .dr_wr   (dr_wr),
    .q       (lrb_flag)
  );

  i2c_ss_flag u_gc (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (gc_hit),
    .clr_i (gc_clr),
    .q     (gcall_flag)
  );

  i2c_ss_flag u_am (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (am_hit),
    .clr_i (am_clr),
    .q     (match_flag)
  );

  always_comb begin
    flag_vec         = '0;
    flag_vec[LRB_POS] = lrb_flag;
    flag_vec[GC_POS]  = gcall_flag;
    flag_vec[AM_POS]  = match_flag;
  end

  generate
    for (genvar i = 0; i < STAT_W; i++) begin : g_stat
      if (i < N_FLAGS) begin : g_flag
        assign status_word[i] = flag_vec[i];
      end else begin : g_pad
        assign status_word[i] = 1'b0;
      end
    end
  endgenerate

  // R5: general call byte sets the flag when no clear is present
  a_r5_gc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && if_en && !addr_10b && !mst_mode && rx_byte == '0
     && !start_stb && !stop_stb) |=> gcall_flag);
  // R6: START, STOP or disable clears general call
  a_r6_gc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb || stop_stb || !if_en) |=> !gcall_flag);
  // R7: own address sets match, R/W bit ignored
  a_r7_am_set: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && if_en && !addr_10b && !mst_mode && !sw_rst && !dr_wr
     && rx_byte[BYTE_W-1:1] == own_addr) |=> match_flag);
  // R9: clears of the match flag
  a_r9_am_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((dr_wr && if_en) || !if_en || sw_rst) |=> !match_flag);
  // R10: no comparison in 10-bit or master mode
  a_r10_no_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_10b || mst_mode) && !sw_rst && !dr_wr && if_en)
      |=> $stable(match_flag));
endmodule

// File: tb/i2c_slv_status_test.sv
module i2c_slv_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_en = 1'b0, addr_10b = 1'b0, mst_mode = 1'b0;
  logic [6:0] own_addr = 7'h2A;
  logic start_stb = 1'b0, stop_stb = 1'b0, addr_stb = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic bit_stb = 1'b0, bit_val = 1'b0, ack_stb = 1'b0, ack_lvl = 1'b0;
  logic dr_wr = 1'b0, sw_rst = 1'b0;
  logic lrb_flag, gcall_flag, match_flag;
  logic [7:0] status_word;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit m_lrb = 0, m_gc = 0, m_am = 0;

  always #2.5 clk = ~clk;

  i2c_slv_status uut (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .own_addr(own_addr),
    .addr_10b(addr_10b), .mst_mode(mst_mode), .start_stb(start_stb),
    .stop_stb(stop_stb), .addr_stb(addr_stb), .rx_byte(rx_byte),
    .bit_stb(bit_stb), .bit_val(bit_val), .ack_stb(ack_stb),
    .ack_lvl(ack_lvl), .dr_wr(dr_wr), .sw_rst(sw_rst),
    .lrb_flag(lrb_flag), .gcall_flag(gcall_flag), .match_flag(match_flag),
    .status_word(status_word)
  );

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    bit ok;
    bit gc_set, am_set, gc_clr, am_clr;
    cycles = cycles + 1;
    if (!rst_n) begin
      m_lrb = 0; m_gc = 0; m_am = 0;
    end else begin
      if (dr_wr) m_lrb = 0;
      else if (ack_stb) m_lrb = ack_lvl;
      else if (bit_stb) m_lrb = bit_val;
      ok = addr_stb && if_en && !addr_10b && !mst_mode;
      gc_set = ok && (rx_byte == 8'h00);
      am_set = ok && ((rx_byte >> 1) == own_addr || rx_byte == 8'h00);
      gc_clr = start_stb || stop_stb || !if_en;
      am_clr = (dr_wr && if_en) || !if_en || sw_rst;
      if (gc_clr) m_gc = 0; else if (gc_set) m_gc = 1;
      if (am_clr) m_am = 0; else if (am_set) m_am = 1;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk(lrb_flag, m_lrb, "R2/R3/R4/R12 last bit vs model");
    chk(gcall_flag, m_gc, "R5/R6/R10/R12 general call vs model");
    chk(match_flag, m_am, "R7/R8/R9/R10/R12 match vs model");
    chk(status_word, {5'b0, m_am, m_gc, m_lrb}, "R11 status packing");
  endtask

  // one clock: inputs already driven; compare after the edge, drop strobes
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
    start_stb = 0; stop_stb = 0; addr_stb = 0; bit_stb = 0;
    ack_stb = 0; dr_wr = 0; sw_rst = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk(status_word, 0, "R1 status in reset");
    chk(lrb_flag | gcall_flag | match_flag, 0, "R1 flags in reset");
    rst_n = 1; if_en = 1;
    tick();
    chk(status_word, 0, "R1 status after reset");

    bit_stb = 1; bit_val = 1; tick();
    chk(lrb_flag, 1, "R2 bit 1 loaded");
    bit_stb = 1; bit_val = 0; tick();
    chk(lrb_flag, 0, "R2 bit 0 loaded");
    ack_stb = 1; ack_lvl = 1; bit_stb = 1; bit_val = 0; tick();
    chk(lrb_flag, 1, "R3 no ACK reads 1, beats data bit");
    tick();
    chk(lrb_flag, 1, "R12 holds without strobe");
    dr_wr = 1; ack_stb = 1; ack_lvl = 1; tick();
    chk(lrb_flag, 0, "R4 write clears over ack strobe");

    addr_stb = 1; rx_byte = {7'h2A, 1'b1}; tick();
    chk(match_flag, 1, "R7 own address with R/W=1");
    chk(gcall_flag, 0, "R5 no general call for own address");
    chk(status_word, 8'h04, "R11 match in bit 2");
    dr_wr = 1; tick();
    chk(match_flag, 0, "R9 write clears match");

    addr_stb = 1; rx_byte = 8'h00; tick();
    chk(gcall_flag, 1, "R5 general call set");
    chk(match_flag, 1, "R8 general call sets match");
    chk(status_word, 8'h06, "R11 bits 1 and 2");
    start_stb = 1; tick();
    chk(gcall_flag, 0, "R6 START clears general call");
    chk(match_flag, 1, "R9 START leaves match");
    sw_rst = 1; addr_stb = 1; rx_byte = {7'h2A, 1'b0}; tick();
    chk(match_flag, 0, "R9 software reset beats set");

    addr_stb = 1; rx_byte = 8'h00; stop_stb = 1; tick();
    chk(gcall_flag, 0, "R6 STOP beats general call set");
    chk(match_flag, 1, "R8 match set despite STOP");
    sw_rst = 1; tick();

    addr_10b = 1; addr_stb = 1; rx_byte = {7'h2A, 1'b0}; tick();
    chk(match_flag, 0, "R10 no compare in 10-bit mode");
    addr_stb = 1; rx_byte = 8'h00; tick();
    chk(gcall_flag, 0, "R10 no general call in 10-bit mode");
    addr_10b = 0; mst_mode = 1; addr_stb = 1; rx_byte = 8'h00; tick();
    chk(match_flag | gcall_flag, 0, "R10 no compare in master mode");
    mst_mode = 0;

    addr_stb = 1; rx_byte = 8'h00; tick();
    if_en = 0; addr_stb = 1; rx_byte = 8'h00; tick();
    chk(gcall_flag, 0, "R6 disable clears general call");
    chk(match_flag, 0, "R9 disable clears match");
    if_en = 1; tick();

    for (int n = 0; n < 4000; n++) begin
      int sel;
      sel = $urandom_range(0, 3);
      own_addr = (n % 500 == 0) ? 7'($urandom) : own_addr;
      rx_byte = (sel == 0) ? {own_addr, 1'($urandom)} :
                (sel == 1) ? 8'h00 : 8'($urandom);
      addr_stb  = ($urandom_range(0, 3) == 0);
      start_stb = ($urandom_range(0, 9) == 0);
      stop_stb  = ($urandom_range(0, 9) == 0);
      bit_stb   = ($urandom_range(0, 2) == 0);
      bit_val   = 1'($urandom);
      ack_stb   = ($urandom_range(0, 4) == 0);
      ack_lvl   = 1'($urandom);
      dr_wr     = ($urandom_range(0, 7) == 0);
      sw_rst    = ($urandom_range(0, 15) == 0);
      if_en     = ($urandom_range(0, 19) != 0);
      addr_10b  = ($urandom_range(0, 9) == 0);
      mst_mode  = ($urandom_range(0, 9) == 0);
      tick();
    end
    finish_run();
  end
endmodule